// File: doc/BRIEF.md
# Serial Port Register Front End

This block sits between a simple word-wide read/write bus and the byte-level engines of an asynchronous serial port. Software sees two word-aligned locations. One is a data location: a read there returns the last byte received, and a write there hands a byte to the transmitter. The other is a status word that shows whether a received byte is waiting, whether received data has been lost, and whether the transmitter can take a new byte.

Bytes come in from a deserializer and go out to a serializer over valid/ready handshakes. The bit-level framing and the line drivers sit outside this block. A received byte and a finished transmission each raise a one-cycle event pulse for an interrupt controller. Reading the data location clears the receive flag as a side effect, and reading the status word clears the data-lost flag.

Bus reads are combinational: `bus_rdata` is valid in the same cycle as the request. Any side effect of a read or write takes place at the clock edge that ends that cycle.

Top module: `sio_regfront`

## Requirements
- R1: After reset the status word reads 0x4 (transmitter ready, no byte waiting, no data lost), `tx_valid` is low, and both event pulses are low.
- R2: A read at offset 0x10 returns the held received byte in bits 7:0. All other bits read as zero.
- R3: Status bit 0 (byte waiting) is set in the cycle after `rx_valid` delivers a byte. It is cleared in the cycle after a read at 0x10, unless a new byte arrives in that same cycle. In that case the new byte is held, the flag stays 1, and no data loss is recorded.
- R4: A write at 0x10 while status bit 2 (transmitter ready) is 1 places `bus_wdata[7:0]` on `tx_data`. It raises `tx_valid` from the next cycle until a cycle with `tx_ready` high, and it clears status bit 2 from the next cycle.
- R5: Status bit 2 stays 0 after the handoff. It returns to 1 in the cycle after a `tx_done` pulse that arrives once the byte has been handed off.
- R6: A write at 0x10 while status bit 2 is 0 is ignored. `tx_data` keeps the byte in progress.
- R7: A byte that arrives while bit 0 is 1, with no data read in that cycle, overwrites the held byte and sets sticky status bit 1. A read at 0x14 clears bit 1 after that cycle.
- R8: `irq_rx` pulses for one cycle, the cycle after a byte is taken. `irq_tx` pulses for one cycle, the cycle after the `tx_done` that completes a transmission.
- R9: Any address other than 0x10 and 0x14, misaligned ones included, reads as zero. Writes to such addresses, and writes to 0x14, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the request cycle |
| rx_valid | input | 1 | Deserializer presents a byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Always 1: a byte is always taken |
| tx_valid | output | 1 | Byte offered to the serializer |
| tx_data | output | 8 | Byte to send |
| tx_ready | input | 1 | Serializer takes the offered byte |
| tx_done | input | 1 | Serializer finished sending the byte |
| irq_rx | output | 1 | Receive event pulse |
| irq_tx | output | 1 | Transmit-complete event pulse |

## Verification
The bench checks the flags, the data and the events at the ports. A receive flag that is stuck or cleared at the wrong time shows up on the next status read and on `irq_rx` one cycle after a byte arrives. A lost overrun mark shows up in the first status read after two back-to-back arrivals. An accepted or dropped transmit write shows up on `tx_data` and `tx_valid` in the very next cycle, and a busy flag that clears too early shows up as a ready bit before `tx_done`. A decoder fault shows up as non-zero data from an unmapped read in the same cycle.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int BYTE_W   = 8;
  localparam int ST_RXRDY = 0;
  localparam int ST_OVR   = 1;
  localparam int ST_TXRDY = 2;

  // Status byte layout; the upper bus bits are zero-extended by the top.
  function automatic logic [BYTE_W-1:0] pack_status(input logic rxrdy,
                                                    input logic ovr,
                                                    input logic txrdy);
    logic [BYTE_W-1:0] s;
    s = '0;
    s[ST_RXRDY] = rxrdy;
    s[ST_OVR]   = ovr;
    s[ST_TXRDY] = txrdy;
    return s;
  endfunction

  function automatic logic [31:0] zext_byte(input logic [BYTE_W-1:0] b);
    return {{(32-BYTE_W){1'b0}}, b};
  endfunction
endpackage

// File: rtl/sio_addr_dec.sv
module sio_addr_dec #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'h10,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h14
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_data,
  output logic              wr_data,
  output logic              rd_stat
);
  logic hit_data, hit_stat;
  assign hit_data = (addr == DATA_OFS);
  assign hit_stat = (addr == STAT_OFS);
  assign rd_data  = sel && !wr && hit_data;
  assign wr_data  = sel &&  wr && hit_data;
  assign rd_stat  = sel && !wr && hit_stat;
endmodule

// File: rtl/sio_rx_hold.sv
module sio_rx_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              rd_take,
  input  logic              clr_ovr,
  output logic [BYTE_W-1:0] byte_q,
  output logic              full_q,
  output logic              ovr_q,
  output logic              evt_q
);
  logic lose;
  // A byte is lost only if the held one is still unread and not read now.
  assign lose = in_valid && full_q && !rd_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      evt_q <= in_valid;
      if (in_valid)     byte_q <= in_byte;
      if (in_valid)     full_q <= 1'b1;
      else if (rd_take) full_q <= 1'b0;
      if (lose)         ovr_q  <= 1'b1;
      else if (clr_ovr) ovr_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_tx_hold.sv
module sio_tx_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              ser_ready,
  input  logic              ser_done,
  output logic              ser_valid,
  output logic [BYTE_W-1:0] byte_q,
  output logic              busy_q,
  output logic              evt_q,
  output logic              accept,
  output logic              finish
);
  logic pend_q;
  assign accept    = wr_req && !busy_q;
  assign finish    = busy_q && !pend_q && ser_done;
  assign ser_valid = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_q <= '0;
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      evt_q <= finish;
      if (accept) begin
        byte_q <= wr_byte;
        busy_q <= 1'b1;
        pend_q <= 1'b1;
      end else begin
        if (pend_q && ser_ready) pend_q <= 1'b0;
        if (finish)              busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sio_regfront.sv
module sio_regfront #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'h10,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  input  logic              tx_done,
  output logic              irq_rx,
  output logic              irq_tx
);
  import sio_pkg::*;
  localparam int PAD_W = DATA_W - BYTE_W;

  // Named internal events, used by the bound checker.
  logic rd_data_evt, wr_data_evt, rd_stat_evt, mapped_rd;
  logic tx_accept, tx_finish;
  logic rx_full, rx_ovr, tx_busy;
  logic [BYTE_W-1:0] rx_byte, stat_byte;

  sio_addr_dec #(.ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .STAT_OFS(STAT_OFS)) u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .rd_data(rd_data_evt), .wr_data(wr_data_evt), .rd_stat(rd_stat_evt)
  );

  sio_rx_hold #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_byte(rx_data),
    .rd_take(rd_data_evt), .clr_ovr(rd_stat_evt),
    .byte_q(rx_byte), .full_q(rx_full), .ovr_q(rx_ovr), .evt_q(irq_rx)
  );

  sio_tx_hold #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_data_evt), .wr_byte(bus_wdata[BYTE_W-1:0]),
    .ser_ready(tx_ready), .ser_done(tx_done), .ser_valid(tx_valid),
    .byte_q(tx_data), .busy_q(tx_busy), .evt_q(irq_tx),
    .accept(tx_accept), .finish(tx_finish)
  );

  assign rx_ready  = 1'b1;
  assign mapped_rd = rd_data_evt || rd_stat_evt;
  assign stat_byte = pack_status(rx_full, rx_ovr, !tx_busy);

  always_comb begin
    if (rd_data_evt)      bus_rdata = {{PAD_W{1'b0}}, rx_byte};
    else if (rd_stat_evt) bus_rdata = {{PAD_W{1'b0}}, stat_byte};
    else                  bus_rdata = '0;
  end
endmodule

// File: rtl/sio_regfront_chk.sv
module sio_regfront_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              mapped_rd,
  input logic              rd_data_evt,
  input logic              rd_stat_evt,
  input logic              rx_valid,
  input logic              rx_full,
  input logic              rx_ovr,
  input logic              tx_busy,
  input logic              tx_valid,
  input logic              tx_done,
  input logic [7:0]        tx_data,
  input logic              irq_rx,
  input logic              irq_tx
);
  a_r9_decode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_data_evt, rd_stat_evt}));
  a_r3_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rx_full);
  a_r3_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_evt && !rx_valid) |=> !rx_full);
  a_r7_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_full && !rd_data_evt) |=> rx_ovr);
  a_r4_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_busy);
  a_r6_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tx_done) |=> $stable(tx_data));
  a_r8_irq_rx: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> irq_rx);
  a_r8_irq_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tx_valid && tx_done) |=> (irq_tx && !tx_busy));
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !mapped_rd) |-> (bus_rdata == '0));
endmodule

bind sio_regfront sio_regfront_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .mapped_rd(mapped_rd), .rd_data_evt(rd_data_evt),
  .rd_stat_evt(rd_stat_evt), .rx_valid(rx_valid), .rx_full(rx_full),
  .rx_ovr(rx_ovr), .tx_busy(tx_busy), .tx_valid(tx_valid), .tx_done(tx_done),
  .tx_data(tx_data), .irq_rx(irq_rx), .irq_tx(irq_tx)
);

// File: tb/test_sio_regfront.sv
module test_sio_regfront;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, irq_rx, irq_tx;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0, tx_done = 1'b0;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  sio_regfront i_sio_regfront (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .tx_done(tx_done), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  // Expected status word, built from the requirement text.
  function automatic logic [31:0] stat(input bit rxrdy, input bit ovr, input bit txrdy);
    return {29'd0, txrdy, ovr, rxrdy};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every read, mid-cycle.
  always @(negedge clk) begin
    if (bus_sel && !bus_wr) begin
      if (exp_q.size() == 0) chk(bus_rdata, 32'hDEAD, "unexpected read");
      else chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    step(); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    step(); bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step(); bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rx_byte(input logic [7:0] b);
    step(); rx_valid = 1'b1; rx_data = b;
    step(); rx_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    // R1 reset state
    chk({31'd0, tx_valid}, 0, "R1 tx_valid");
    chk({30'd0, irq_rx, irq_tx}, 0, "R1 irq");
    rd(8'h14, stat(0, 0, 1), "R1 status");

    // R3/R8/R2 single receive
    rx_byte(8'hA5);
    chk({31'd0, irq_rx}, 1, "R8 irq_rx pulse");
    step();
    chk({31'd0, irq_rx}, 0, "R8 irq_rx one cycle");
    rd(8'h14, stat(1, 0, 1), "R3 set");
    rd(8'h10, 32'h0000_00A5, "R2 data");
    rd(8'h14, stat(0, 0, 1), "R3 cleared");

    // R7 overrun
    rx_byte(8'h11);
    rx_byte(8'h22);
    rd(8'h14, stat(1, 1, 1), "R7 overrun set");
    rd(8'h14, stat(1, 0, 1), "R7 cleared by status read");
    rd(8'h10, 32'h22, "R7 newest byte kept");

    // R3 read and arrival in the same cycle
    rx_byte(8'h33);
    exp_q.push_back(32'h33); tag_q.push_back("R3 same-cycle read data");
    step(); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h10; rx_valid = 1'b1; rx_data = 8'h44;
    step(); bus_sel = 1'b0; rx_valid = 1'b0;
    rd(8'h14, stat(1, 0, 1), "R3 same-cycle flag kept, no loss");
    rd(8'h10, 32'h44, "R3 same-cycle new byte");

    // R4 transmit write
    wr(8'h10, 32'hFFFF_FF3C);
    chk({31'd0, tx_valid}, 1, "R4 tx_valid");
    chk({24'd0, tx_data}, 32'h3C, "R4 tx_data");
    rd(8'h14, stat(0, 0, 0), "R4 tx not ready");
    // R6 write while busy
    wr(8'h10, 32'h99);
    chk({24'd0, tx_data}, 32'h3C, "R6 ignored write");
    step(); tx_ready = 1'b1;
    step(); tx_ready = 1'b0;
    chk({31'd0, tx_valid}, 0, "R4 valid drops after handoff");
    rd(8'h14, stat(0, 0, 0), "R5 still busy");
    step(); tx_done = 1'b1;
    step(); tx_done = 1'b0;
    chk({31'd0, irq_tx}, 1, "R8 irq_tx pulse");
    rd(8'h14, stat(0, 0, 1), "R5 ready again");
    wr(8'h10, 32'h5A);
    chk({24'd0, tx_data}, 32'h5A, "R4 second byte");
    step(); tx_ready = 1'b1;
    step(); tx_ready = 1'b0; tx_done = 1'b1;
    step(); tx_done = 1'b0;

    // R9 unmapped
    rd(8'h00, 0, "R9 offset 0");
    rd(8'h11, 0, "R9 misaligned");
    rd(8'h18, 0, "R9 offset 0x18");
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, stat(0, 0, 1), "R9 status write ignored");
    wr(8'h04, 32'h77);
    chk({31'd0, tx_valid}, 0, "R9 unmapped write no tx");
    rd(8'h10, 32'h44, "R9 data kept");

    repeat (2) step();
    chk(exp_q.size(), 0, "scoreboard drained");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule